// File: doc/BRIEF.md
# Latched Multiplexed Seven-Segment Display Scanner

This block sits between a four-digit BCD counter and a common-cathode seven-segment display. It keeps a copy of the count in a level-sensitive hold latch. A selection input decides whether the display shows the live count or that held copy. The chosen four digits share one segment bus. They are shown one at a time, and each has its own digit-enable line. Each digit's nibble is decoded to segment levels, where a lit segment is driven high.

The scan runs by itself. An internal divider, sized from the system clock frequency, produces a slot tick. Each digit gets `TICKS_PER_DIGIT` ticks, and the whole display is refreshed `SCAN_HZ` times per second. No external scan clock is needed.

The scan sequencer has two states:

- `ST_BLANK`: one tick long. All digit enables and all segments are off, so no ghost image carries over from the previous digit.
- `ST_DRIVE`: `TICKS_PER_DIGIT-1` ticks long. It enables the current digit and drives its decoded segments.

The transitions are:

- reset → `ST_BLANK` at digit 0.
- `ST_BLANK` → `ST_DRIVE` on the next tick.
- `ST_DRIVE` → `ST_DRIVE` on a tick that is not the last of the slot.
- `ST_DRIVE` → `ST_BLANK` on the last tick of the slot. This transition also advances the digit index, wrapping from the top digit back to 0.

Top module: `disp_scan_top`

## Requirements
- R1: While `latch_en` is 1 the hold path is transparent and shows `count_bcd`. While `latch_en` is 0 it shows the `count_bcd` value sampled at the last rising clock edge where `latch_en` was 1.
- R2: With `show_live` = 1 the displayed digits come from `count_bcd`. With `show_live` = 0 they come from the hold path of R1.
- R3: At most one bit of `dig_en` is 1 at any time. Digit k is enabled by `dig_en[k]` and shows nibble `count_bcd[4k+3:4k]`. Digits are scanned in order 0, 1, 2, 3 and then the scan wraps to 0.
- R4: Each digit slot lasts `TICKS_PER_DIGIT` ticks. During the first tick of each slot, `seg` and `dig_en` are both all zero. During the remaining ticks, the slot's digit is enabled.
- R5: A tick occurs every `DIV = CLK_HZ/(SCAN_HZ*DIGITS*TICKS_PER_DIGIT)` clocks, counted from reset release. One full scan therefore takes `DIGITS*TICKS_PER_DIGIT*DIV` clocks.
- R6: The segment map is `seg[0]`=a, `seg[1]`=b, and so on up to `seg[6]`=g, with 1 meaning lit. The codes 0 to 9 give hex patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F. The codes 10 to 15 give 00.
- R7: While `rst_n` is 0, `seg` and `dig_en` are all zero and the held copy is cleared to 0000. After release the scan starts with the blank tick of digit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_bcd | input | 16 | Live four-digit BCD count, digit 0 in bits 3:0 |
| latch_en | input | 1 | 1 = hold path transparent, 0 = hold |
| show_live | input | 1 | 1 = show live count, 0 = show held copy |
| seg | output | 7 | Segment levels a..g, active high |
| dig_en | output | 4 | One-hot digit enables, active high |

## Verification
The bench chases the following corner cases and the failure each one exposes:

- The edge where `latch_en` falls: a hold latch that captured one cycle late, or kept following the count, would show the wrong digits in held mode.
- Switching `show_live` while the hold is closed: a swapped select would show the live count in held mode.
- Codes 10 to 15: a decoder that did not blank them would light garbage segments.
- Slot boundaries: a missing blank tick, a wrong divider ratio or a reversed scan order would put a digit enable in the wrong cycle. The bench also measures the full scan period directly against the R5 formula.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;

    typedef enum logic [0:0] {
        ST_BLANK = 1'b0,
        ST_DRIVE = 1'b1
    } scan_state_t;

    // seg[0]=a ... seg[6]=g, high = lit; non-decimal codes dark
    function automatic logic [6:0] bcd_to_seg(input logic [3:0] code);
        logic [6:0] pat;
        unique case (code)
            4'd0:    pat = 7'h3F;
            4'd1:    pat = 7'h06;
            4'd2:    pat = 7'h5B;
            4'd3:    pat = 7'h4F;
            4'd4:    pat = 7'h66;
            4'd5:    pat = 7'h6D;
            4'd6:    pat = 7'h7D;
            4'd7:    pat = 7'h07;
            4'd8:    pat = 7'h7F;
            4'd9:    pat = 7'h6F;
            default: pat = 7'h00;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/scan_divider.sv
module scan_divider #(
    parameter int DIV = 7812
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIVW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIVW-1:0] LAST = DIVW'(DIV - 1);

    logic [DIVW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    // R5
    tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0));

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/bcd_hold_latch.sv
module bcd_hold_latch #(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] count_in,
    input  logic         latch_en,
    input  logic         show_live,
    output logic [W-1:0] shown
);
    logic [W-1:0] held;
    logic [W-1:0] hold_path;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            held <= '0;
        else if (latch_en)
            held <= count_in;
    end

    always_comb begin
        hold_path = latch_en ? count_in : held;
        shown     = show_live ? count_in : hold_path;
    end

    // R1
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> $stable(held));

    // R2
    live_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        show_live |-> (shown == count_in));

endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
    import disp_scan_pkg::*;
#(
    parameter int DIGITS          = 4,
    parameter int TICKS_PER_DIGIT = 4,
    localparam int IDXW = (DIGITS > 1) ? $clog2(DIGITS) : 1,
    localparam int TCW  = (TICKS_PER_DIGIT > 2) ? $clog2(TICKS_PER_DIGIT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [IDXW-1:0]   dig_idx,
    output logic              driving,
    output logic [DIGITS-1:0] dig_en
);
    localparam logic [IDXW-1:0] TOP_IDX   = IDXW'(DIGITS - 1);
    localparam logic [TCW-1:0]  LAST_HOLD = TCW'(TICKS_PER_DIGIT - 2);

    scan_state_t     state;
    logic [TCW-1:0]  hold_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_BLANK;
            dig_idx  <= '0;
            hold_cnt <= '0;
        end else if (tick) begin
            unique case (state)
                ST_BLANK: begin
                    state    <= ST_DRIVE;
                    hold_cnt <= '0;
                end
                ST_DRIVE: begin
                    if (hold_cnt == LAST_HOLD) begin
                        state   <= ST_BLANK;
                        dig_idx <= (dig_idx == TOP_IDX) ? '0 : dig_idx + 1'b1;
                    end else begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        driving = 1'b0;
        dig_en  = '0;
        unique case (state)
            ST_BLANK: ;
            ST_DRIVE: begin
                driving = 1'b1;
                dig_en  = DIGITS'(1) << dig_idx;
            end
        endcase
    end

    // R3
    dig_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_en));

    // R3
    idx_moves_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dig_idx) |-> (state == ST_BLANK));

    // R5
    state_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state) |-> $past(tick));

endmodule

// File: rtl/disp_scan_top.sv
module disp_scan_top
    import disp_scan_pkg::*;
#(
    parameter int CLK_HZ          = 125_000_000,
    parameter int SCAN_HZ         = 1000,
    parameter int TICKS_PER_DIGIT = 4,
    localparam int DIGITS = 4,
    localparam int RAW_DIV = CLK_HZ / (SCAN_HZ * DIGITS * TICKS_PER_DIGIT),
    localparam int DIV     = (RAW_DIV > 1) ? RAW_DIV : 2,
    localparam int IDXW    = $clog2(DIGITS)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] count_bcd,
    input  logic        latch_en,
    input  logic        show_live,
    output logic [6:0]  seg,
    output logic [3:0]  dig_en
);
    logic            tick;
    logic [15:0]     shown;
    logic [IDXW-1:0] dig_idx;
    logic            driving;
    logic [3:0]      nibble;

    scan_divider #(.DIV(DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    bcd_hold_latch #(.DIGITS(DIGITS)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_in  (count_bcd),
        .latch_en  (latch_en),
        .show_live (show_live),
        .shown     (shown)
    );

    scan_fsm #(
        .DIGITS          (DIGITS),
        .TICKS_PER_DIGIT (TICKS_PER_DIGIT)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .dig_idx (dig_idx),
        .driving (driving),
        .dig_en  (dig_en)
    );

    always_comb begin
        nibble = shown[dig_idx*4 +: 4];
        seg    = driving ? bcd_to_seg(nibble) : 7'h00;
    end

    // R4
    lit_needs_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg != 7'h00) |-> $onehot(dig_en));

endmodule

// File: tb/tb_disp_scan_top.sv
`timescale 1ns/1ps
module tb_disp_scan_top;
    localparam int CLK_HZ = 64000;
    localparam int SCAN_HZ = 1000;
    localparam int TPD = 4;
    localparam int NDIG = 4;
    localparam int DIV = CLK_HZ / (SCAN_HZ * NDIG * TPD);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] count_bcd = 16'h0;
    logic latch_en = 1'b0;
    logic show_live = 1'b0;
    logic [6:0] seg;
    logic [3:0] dig_en;

    int checks = 0;
    int bad = 0;
    int n = 0;
    logic [15:0] m_held = 16'h0;
    logic [6:0] segtab [16];

    always #4 clk = ~clk;

    disp_scan_top #(.CLK_HZ(CLK_HZ), .SCAN_HZ(SCAN_HZ), .TICKS_PER_DIGIT(TPD)) dut (
        .clk(clk), .rst_n(rst_n), .count_bcd(count_bcd), .latch_en(latch_en),
        .show_live(show_live), .seg(seg), .dig_en(dig_en)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at n=%0d", tag, act, exp, n);
        end
    endtask

    // one clock: inputs applied, model advanced at posedge, compare at negedge
    task automatic step(input logic [15:0] c, input logic le, input logic live);
        int t, p, d, blank;
        logic [15:0] disp;
        logic [3:0] nib;
        count_bcd = c; latch_en = le; show_live = live;
        @(posedge clk);
        if (rst_n) begin
            n++;
            if (le) m_held = c;
        end
        @(negedge clk);
        t = n / DIV;
        p = t % (NDIG * TPD);
        d = p / TPD;
        blank = ((p % TPD) == 0);
        disp = live ? c : (le ? c : m_held);
        nib = disp[d*4 +: 4];
        check(blank ? "R4 dig_en" : "R3/R5 dig_en", dig_en, blank ? 0 : (1 << d));
        if (blank) check("R4 seg", seg, 0);
        else if (nib > 9) check("R6 seg", seg, 0);
        else if (live) check("R2 seg", seg, segtab[nib]);
        else check("R1 seg", seg, segtab[nib]);
    endtask

    initial begin
        #(8 * 190000);
        bad++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int rise_a, rise_b;
        segtab[0] = 7'h3F; segtab[1] = 7'h06; segtab[2] = 7'h5B; segtab[3] = 7'h4F;
        segtab[4] = 7'h66; segtab[5] = 7'h6D; segtab[6] = 7'h7D; segtab[7] = 7'h07;
        segtab[8] = 7'h7F; segtab[9] = 7'h6F;
        for (int i = 10; i < 16; i++) segtab[i] = 7'h00;

        // R7: reset state
        count_bcd = 16'h8888; latch_en = 1'b1; show_live = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 seg in reset", seg, 0);
        check("R7 dig_en in reset", dig_en, 0);
        latch_en = 1'b0; show_live = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_held = 16'h0;
        n = 0;

        // R7: held copy cleared -> shows 0000
        for (int i = 0; i < 70; i++) step(16'h1234, 1'b0, 1'b0);

        // R2/R3: live mode with fixed digits, then varying patterns
        for (int i = 0; i < 130; i++) step(16'h4321, 1'b0, 1'b1);
        for (int i = 0; i < 400; i++) step(16'(((i / 7) % 10) * 16'h1111 + 16'h0), 1'b0, 1'b1);

        // R6: non-decimal codes in every position
        for (int i = 0; i < 130; i++) step(16'hFEDA, 1'b1, 1'b1);
        for (int i = 0; i < 130; i++) step(16'h9BC0, 1'b1, 1'b0);

        // R1: capture then hold while count moves
        for (int i = 0; i < 10; i++) step(16'h5678, 1'b1, 1'b0);
        for (int i = 0; i < 200; i++) step(16'($urandom), 1'b0, 1'b0);
        // R2: swap to live and back while held
        for (int i = 0; i < 100; i++) step(16'h0246, 1'b0, 1'b1);
        for (int i = 0; i < 100; i++) step(16'h0246, 1'b0, 1'b0);

        // R1: toggling latch_en with random counts and modes
        for (int i = 0; i < 1500; i++)
            step(16'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) == 0));

        // R5: full scan period measured on digit 0 enable rises
        rise_a = -1; rise_b = -1;
        for (int i = 0; i < 3 * NDIG * TPD * DIV; i++) begin
            logic prev;
            prev = dig_en[0];
            step(16'h8888, 1'b0, 1'b1);
            if (!prev && dig_en[0]) begin
                if (rise_a < 0) rise_a = n;
                else if (rise_b < 0) rise_b = n;
            end
        end
        check("R5 scan period", rise_b - rise_a, NDIG * TPD * DIV);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule